// File: doc/BRIEF.md
# Baud-Phase Carrier Detect

This block raises a carrier-present flag when the sliced symbol stream from a demodulator shows transitions at a steady baud rate. A signed phase accumulator advances by a programmable step on every input sample, so it wraps once per symbol period. Each symbol change is scored by where it lands on that wheel. A change close to the accumulator's zero adds to a saturating confidence count. A change far from zero subtracts from it. Every change also scales the accumulator by a fractional factor, which pulls the local phase toward the observed edge.

The demodulator delivers a signed sample with a strobe, and the block slices it by sign. The step, score increment, score decrement, count ceiling, flag threshold and Q15 pull factor are live configuration inputs. The single output is the detect flag. It follows the count on each strobed sample.

Top module: `pll_dcd`

## Requirements
- R1: While rst_ni is low, the flag is 0, the count is 0, the accumulator is 0 and the stored symbol is 0.
- R2: The symbol of a strobed sample is 1 when demod_i, read as two's complement, is strictly above zero. Zero and negative samples give symbol 0.
- R3: When sample_valid_i is low, the accumulator, the stored symbol, the count and dcd_o all keep their values, whatever the other inputs do.
- R4: On every strobed sample the accumulator advances by step_i modulo 2^32, giving the advanced phase.
- R5: A transition is a strobed symbol that differs from the stored one. If the magnitude of the advanced phase is strictly below inc_i, the count rises by inc_i.
- R6: If a transition lands with a phase magnitude of inc_i or more, the count falls by dec_i, and it never goes below 0.
- R7: On a transition, the accumulator becomes the advanced phase times adjust_i (signed Q15), arithmetically shifted right by 15 and kept to its low 32 bits. Without a transition it keeps the advanced phase.
- R8: On every strobed sample, the count is limited to at most max_i after the score update.
- R9: dcd_o is 1 exactly when the count is above thres_i. It is updated on each strobed sample and is visible from the clock edge that takes the sample.
- R10: A clean alternating pattern whose transitions line up with the accumulator's wrap drives dcd_o high. A random symbol stream leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_valid_i | input | 1 | Strobe qualifying demod_i |
| demod_i | input | SAMPLE_W | Signed demodulator output |
| step_i | input | ACC_W | Phase advance per sample |
| inc_i | input | CNT_W | Score increment and near-zero window |
| dec_i | input | CNT_W | Score decrement |
| max_i | input | CNT_W | Count ceiling |
| thres_i | input | CNT_W | Flag threshold |
| adjust_i | input | 16 | Signed Q15 phase pull factor |
| dcd_o | output | 1 | Carrier detect flag |

## Verification
The phase pull is the hardest behaviour to see from the ports. Its effect only reaches dcd_o through later near or far decisions. A long random symbol run drives transitions at arbitrary phases, so the Q15 scaling produces accumulator values off the step grid. The bench follows these with a reference model every cycle. The strict window boundary is reached by setting the step to exactly inc_i and to one less, with a zero threshold, so that a single transition decides the flag.

// File: rtl/pll_dcd_pkg.sv
package pll_dcd_pkg;
  localparam int unsigned ADJ_W  = 16;
  localparam int unsigned FRAC_W = 15;
endpackage

// File: rtl/pll_dcd_slicer.sv
module pll_dcd_slicer #(
  parameter int unsigned SAMPLE_W = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic signed [SAMPLE_W-1:0] demod_i,
  output logic                       edge_o
);
  logic sym;
  logic last_q;

  assign sym    = (demod_i > 0);
  assign edge_o = valid_i && (sym != last_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      last_q <= 1'b0;
    else if (valid_i) last_q <= sym;
  end

  assert_sign_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (demod_i <= 0) |=> !last_q);
  assert_hold_sym_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(last_q));
endmodule

// File: rtl/pll_dcd_phase.sv
module pll_dcd_phase
  import pll_dcd_pkg::*;
#(
  parameter int unsigned ACC_W = 32,
  parameter int unsigned CNT_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic                    edge_i,
  input  logic [ACC_W-1:0]        step_i,
  input  logic [CNT_W-1:0]        win_i,
  input  logic signed [ADJ_W-1:0] adjust_i,
  output logic                    near_o
);
  localparam int unsigned PROD_W = ACC_W + ADJ_W;
  localparam int unsigned CMP_W  = ((ACC_W > CNT_W) ? ACC_W : CNT_W) + 1;

  logic [ACC_W-1:0]         acc_q;
  logic [ACC_W-1:0]         acc_adv;
  logic [ACC_W-1:0]         mag;
  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         acc_pull;

  assign acc_adv  = acc_q + step_i;
  assign mag      = acc_adv[ACC_W-1] ? (~acc_adv + ACC_W'(1)) : acc_adv;
  assign near_o   = CMP_W'(mag) < CMP_W'(win_i);
  assign prod     = $signed(acc_adv) * adjust_i;
  assign acc_pull = ACC_W'(prod >>> FRAC_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (valid_i) acc_q <= edge_i ? acc_pull : acc_adv;
  end

  assert_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !edge_i |=> acc_q == $past(acc_q) + $past(step_i));
  assert_hold_acc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(acc_q));
endmodule

// File: rtl/pll_dcd_score.sv
module pll_dcd_score #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             edge_i,
  input  logic             near_i,
  input  logic [CNT_W-1:0] inc_i,
  input  logic [CNT_W-1:0] dec_i,
  input  logic [CNT_W-1:0] max_i,
  input  logic [CNT_W-1:0] thres_i,
  output logic             dcd_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   raised;
  logic [CNT_W-1:0] scored;
  logic             dcd_q;

  assign raised = {1'b0, cnt_q} + {1'b0, inc_i};

  always_comb begin
    scored = cnt_q;
    if (edge_i) begin
      if (near_i)            scored = (raised > {1'b0, max_i}) ? max_i : raised[CNT_W-1:0];
      else if (cnt_q > dec_i) scored = cnt_q - dec_i;
      else                   scored = '0;
    end
    cnt_d = (scored > max_i) ? max_i : scored;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dcd_q <= 1'b0;
    end else if (valid_i) begin
      cnt_q <= cnt_d;
      dcd_q <= cnt_d > thres_i;
    end
  end

  assign dcd_o = dcd_q;

  assert_cap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> cnt_q <= $past(max_i));
  assert_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> dcd_o == (cnt_q > $past(thres_i)));
  assert_floor_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && edge_i && !near_i && (cnt_q <= dec_i) |=> cnt_q == '0);
  assert_hold_cnt_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_q) && $stable(dcd_o));
endmodule

// File: rtl/pll_dcd.sv
module pll_dcd
  import pll_dcd_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 16,
  parameter int unsigned ACC_W    = 32,
  parameter int unsigned CNT_W    = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sample_valid_i,
  input  logic signed [SAMPLE_W-1:0] demod_i,
  input  logic [ACC_W-1:0]           step_i,
  input  logic [CNT_W-1:0]           inc_i,
  input  logic [CNT_W-1:0]           dec_i,
  input  logic [CNT_W-1:0]           max_i,
  input  logic [CNT_W-1:0]           thres_i,
  input  logic signed [ADJ_W-1:0]    adjust_i,
  output logic                       dcd_o
);
  logic sym_edge;
  logic near;

  pll_dcd_slicer #(.SAMPLE_W(SAMPLE_W)) u_slicer (
    .clk_i, .rst_ni, .valid_i(sample_valid_i), .demod_i, .edge_o(sym_edge)
  );

  pll_dcd_phase #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_phase (
    .clk_i, .rst_ni, .valid_i(sample_valid_i), .edge_i(sym_edge),
    .step_i, .win_i(inc_i), .adjust_i, .near_o(near)
  );

  pll_dcd_score #(.CNT_W(CNT_W)) u_score (
    .clk_i, .rst_ni, .valid_i(sample_valid_i), .edge_i(sym_edge), .near_i(near),
    .inc_i, .dec_i, .max_i, .thres_i, .dcd_o
  );
endmodule

// File: tb/sim_pll_dcd.sv
module sim_pll_dcd;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               vld = 1'b0;
  logic signed [15:0] demod = '0;
  logic [31:0]        step = '0, inc = '0, dec = '0, mx = '0, thr = '0;
  logic signed [15:0] adj = '0;
  logic               dcd;

  int checks = 0;
  int errors = 0;

  longint m_acc, m_cnt;
  bit     m_last, m_dcd;

  always #10 clk = ~clk;

  pll_dcd u0 (
    .clk_i(clk), .rst_ni(rst_n), .sample_valid_i(vld), .demod_i(demod),
    .step_i(step), .inc_i(inc), .dec_i(dec), .max_i(mx), .thres_i(thr),
    .adjust_i(adj), .dcd_o(dcd)
  );

  function automatic longint wrap32(longint x);
    longint y = x & 64'hFFFF_FFFF;
    if (y >= 64'sh8000_0000) y -= 64'sh1_0000_0000;
    return y;
  endfunction

  task automatic check(string tag, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s dcd_o=%0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    bit     sym  = (demod > 0);
    longint adv  = wrap32(m_acc + longint'(step));
    longint mag  = (adv < 0) ? -adv : adv;
    if (sym != m_last) begin
      if (mag < longint'(inc)) m_cnt += longint'(inc);
      else if (m_cnt > longint'(dec)) m_cnt -= longint'(dec);
      else m_cnt = 0;
      m_acc = wrap32((adv * longint'(adj)) >>> 15);
    end else m_acc = adv;
    if (m_cnt > longint'(mx)) m_cnt = longint'(mx);
    m_last = sym;
    m_dcd  = (m_cnt > longint'(thr));
  endtask

  // drive after a negedge, step at posedge, compare at next negedge
  task automatic drive(bit v, logic signed [15:0] d, string tag);
    vld = v; demod = d;
    @(posedge clk);
    if (v) model_step();
    @(negedge clk);
    check(tag, dcd, m_dcd);
    vld = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    m_acc = 0; m_cnt = 0; m_last = 0; m_dcd = 0;
    @(negedge clk); @(negedge clk);
    check("R1 reset flag", dcd, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    step = 32'h4000_0000; inc = 32'h0800_0000; dec = 32'h0800_0000;
    mx = 32'h4000_0000; thr = 32'h2000_0000; adj = 16'sd24576;
    do_reset();

    // R10 clean alternation, 4 samples per symbol, edges on wrap
    for (int s = 0; s < 60; s++)
      for (int k = 0; k < 4; k++)
        drive(1'b1, (s % 2 == 0) ? 16'sd900 : -16'sd900, "R5 R8 R10 clean");
    check("R10 clean asserts", dcd, 1'b1);

    // R3: symbol toggles and config changes with no strobe
    for (int k = 0; k < 8; k++) begin
      thr = 32'hFFFF_FFFF;
      drive(1'b0, (k % 2 == 0) ? 16'sd500 : -16'sd500, "R3 no strobe");
    end
    thr = 32'h2000_0000;
    check("R3 flag kept", dcd, 1'b1);

    // R10 noise
    do_reset();
    for (int k = 0; k < 3000; k++)
      drive(1'b1, 16'($signed($urandom_range(0, 2000)) - 1000), "R6 R7 R10 noise");
    check("R10 noise low", dcd, 1'b0);

    // R5/R6 window boundary with zero threshold
    thr = 32'd0; inc = 32'd1000; dec = 32'd5; mx = 32'd100000; adj = 16'sd16384;
    do_reset();
    step = 32'd999;
    drive(1'b1, 16'sd7, "R5 inside window");
    check("R5 near raises", dcd, 1'b1);
    do_reset();
    step = 32'd1000;
    drive(1'b1, 16'sd7, "R6 at window edge");
    check("R6 edge not near, floor 0", dcd, 1'b0);

    // R2 zero and negatives slice to 0
    do_reset();
    step = 32'd1;
    drive(1'b1, 16'sd0, "R2 zero");
    check("R2 zero no edge", dcd, 1'b0);
    drive(1'b1, -16'sd32768, "R2 negative");
    check("R2 negative no edge", dcd, 1'b0);
    drive(1'b1, 16'sd1, "R2 positive");
    check("R2 positive edge", dcd, 1'b1);

    // R8 ceiling, R9 threshold
    do_reset();
    mx = 32'd500; thr = 32'd500; step = 32'd1;
    drive(1'b1, 16'sd3, "R8 clamp");
    check("R8 clamped to max not above thres", dcd, 1'b0);
    thr = 32'd499;
    drive(1'b1, 16'sd3, "R9 threshold lowered");
    check("R9 count above thres", dcd, 1'b1);
    mx = 32'd10;
    drive(1'b1, 16'sd3, "R8 max lowered");
    check("R8 lowered max clamps", dcd, 1'b0);

    // R4/R7 mixed steps and pulls
    do_reset();
    step = 32'h2345_6789; inc = 32'h1000_0000; dec = 32'h0100_0000;
    mx = 32'h7000_0000; thr = 32'h1000_0000; adj = -16'sd12000;
    for (int k = 0; k < 400; k++)
      drive(1'b1, (k % 3 == 0) ? 16'sd10 : -16'sd10, "R4 R7 pull");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule